// File: doc/BRIEF.md
# Byte Predicate Rule Matcher

The block evaluates one 16-byte data window per cycle against 32 programmable byte tests and names the strongest rule that the window satisfies. Each test slot picks one byte of the window by index, clears bits with a mask, subtracts a constant modulo 256 and asks whether the signed result exceeds a threshold. One setting covers equality, ranges, caseless letters and negation. Neighbouring slots form a rule. Two 32-bit vectors mark the first and the last slot of every rule, and one binary addition folds each group of slot results into a single bit at the rule's top slot.

Rules are placed by priority, and a higher slot position beats a lower one. The position of the winning top slot selects an entry in a 32-entry ID table. A global mode bit selects tight packing, where rules sit edge to edge, or loose packing, where every rule ends in a guard slot that never fires. A host loads all settings through a single-cycle write port while the data path runs at one window per clock.

Top module: `byte_pred_matcher`

## Requirements
- R1: A write with cfg_we_i=1 updates one word: addresses 0..31 set slot settings, 32..63 set the ID entry for position addr-32 (data bits 7:0), 64 sets the first-slot vector, 65 the last-slot vector, and 66 bit 0 sets the mode (1 = loose).
- R2: Slot word layout: bits 3:0 select window byte (byte k at in_win_i[8k+7:8k]), bits 15:8 are the AND mask, bits 23:16 the subtract constant, bits 31:24 the threshold; the slot fires when signed((byte & mask) - constant) > signed(threshold).
- R3: With mask 0xFF, constant X-127 mod 256 and threshold 126, a slot fires exactly when its byte equals X.
- R4: In tight mode, a rule whose slots are contiguous, with the first slot marked in the first-slot vector and the last in the last-slot vector, yields its top bit only when every slot of the rule fires; a partial match never spills into another rule.
- R5: A rule whose first-slot vector holds two adjacent marked bits at its low end matches when either of those alternative slots fires and all slots above them fire.
- R6: In loose mode each rule ends in a guard slot that never fires, and the rule's top bit is the carry out of its other slots after adding the first-slot vector.
- R7: When several rules match, the one whose top slot has the highest position wins.
- R8: On a match, match_o=1 and match_id_o is the ID entry at the winner's position; with no match, match_o=0 and match_id_o=0.
- R9: out_valid_o follows in_valid_i exactly two clocks later, and a new window is accepted every clock.
- R10: Reset clears the outputs and every setting, so with all settings at zero no slot fires and no window matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Settings write strobe |
| cfg_addr_i | input | 7 | Settings word address |
| cfg_wdata_i | input | 32 | Settings write data |
| in_valid_i | input | 1 | Window valid |
| in_win_i | input | 128 | Data window, byte 0 in the low bits |
| out_valid_o | output | 1 | Result valid |
| match_o | output | 1 | A rule matched |
| match_id_o | output | 8 | ID of the winning rule, 0 if none |

## Verification
The hardest case to reach is a partial match, where every slot of a rule except the top one fires. The addition then carries into the top position, and only the final mask keeps that carry from reporting a false hit. The stimulus aims at this case with windows that differ from a programmed word only in its last byte. It also includes an alternative whose carry enters from a two-bit first-slot constant, and windows that satisfy two rules at once, so that the priority order decides the result. All of these windows run back to back, one per clock, so every result is checked while the pipeline is full.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  localparam int WIN_BYTES = 16;
  localparam int IDX_W     = $clog2(WIN_BYTES);
  localparam int CFG_W     = 32;

  typedef struct packed {
    logic [7:0]       thr;
    logic [7:0]       sub;
    logic [7:0]       msk;
    logic [3:0]       rsv;
    logic [IDX_W-1:0] idx;
  } slot_cfg_t;
endpackage

// File: rtl/bpm_slot_eval.sv
module bpm_slot_eval
  import bpm_pkg::*;
(
  input  logic [WIN_BYTES*8-1:0] win_i,
  input  slot_cfg_t              cfg_i,
  output logic                   hit_o
);
  logic [7:0] sel_byte;
  logic [7:0] masked;
  logic [7:0] shifted;

  always_comb begin
    sel_byte = win_i[cfg_i.idx*8 +: 8];
    masked   = sel_byte & cfg_i.msk;
    shifted  = masked - cfg_i.sub;
    hit_o    = $signed(shifted) > $signed(cfg_i.thr);
  end

  // equality encoding: byte == sub + 127
  always_comb begin
    if (!$isunknown({win_i, cfg_i}) && cfg_i.msk == 8'hFF && cfg_i.thr == 8'd126)
      assert_eq_R3: assert (hit_o == (sel_byte == 8'(cfg_i.sub + 8'd127)))
        else $error("equality slot mismatch");
  end
endmodule

// File: rtl/bpm_group_and.sv
module bpm_group_and #(
  parameter int N = 32
) (
  input  logic [N-1:0] res_i,
  input  logic [N-1:0] low_i,
  input  logic [N-1:0] high_i,
  input  logic         loose_i,
  output logic [N-1:0] out_o
);
  logic [N-1:0] holed;
  logic [N-1:0] sum_tight;
  logic [N-1:0] sum_loose;

  always_comb begin
    holed     = res_i & ~high_i;
    sum_tight = holed + low_i;
    sum_loose = res_i + low_i;
    if (loose_i) out_o = sum_loose & high_i;
    else         out_o = sum_tight & res_i & high_i;
  end

  // tight: a reported top bit needs its own slot to fire
  always_comb begin
    if (!$isunknown({res_i, low_i, high_i, loose_i}) && !loose_i)
      assert_top_fires_R4: assert ((out_o & ~res_i) == '0)
        else $error("tight rule reported without top slot");
  end
endmodule

// File: rtl/bpm_prio_id.sv
module bpm_prio_id #(
  parameter int N    = 32,
  parameter int ID_W = 8
) (
  input  logic [N-1:0]           vec_i,
  input  logic [N-1:0][ID_W-1:0] ids_i,
  output logic                   any_o,
  output logic [ID_W-1:0]        id_o
);
  localparam int POS_W = $clog2(N);
  logic [POS_W-1:0] pos;

  always_comb begin
    pos = '0;
    for (int k = 0; k < N; k++)
      if (vec_i[k]) pos = POS_W'(k);
    any_o = |vec_i;
    id_o  = any_o ? ids_i[pos] : '0;
  end

  always_comb begin
    if (!$isunknown(vec_i) && any_o)
      assert_highest_R7: assert (vec_i[pos] && ((vec_i >> pos) == N'(1)))
        else $error("winner is not the highest set bit");
  end
endmodule

// File: rtl/byte_pred_matcher.sv
module byte_pred_matcher
  import bpm_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int ID_W      = 8,
  parameter int ADDR_W    = 7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [ADDR_W-1:0]      cfg_addr_i,
  input  logic [CFG_W-1:0]       cfg_wdata_i,
  input  logic                   in_valid_i,
  input  logic [WIN_BYTES*8-1:0] in_win_i,
  output logic                   out_valid_o,
  output logic                   match_o,
  output logic [ID_W-1:0]        match_id_o
);
  localparam int POS_W     = $clog2(NUM_SLOTS);
  localparam int ID_BASE   = NUM_SLOTS;
  localparam int LOW_ADDR  = 2 * NUM_SLOTS;
  localparam int HIGH_ADDR = LOW_ADDR + 1;
  localparam int MODE_ADDR = LOW_ADDR + 2;

  slot_cfg_t [NUM_SLOTS-1:0]           slot_q;
  logic [NUM_SLOTS-1:0][ID_W-1:0]      id_tab_q;
  logic [NUM_SLOTS-1:0]                low_q, high_q;
  logic                                loose_q;

  // settings write port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q   <= '0;
      id_tab_q <= '0;
      low_q    <= '0;
      high_q   <= '0;
      loose_q  <= 1'b0;
    end else if (cfg_we_i) begin
      if (cfg_addr_i < ADDR_W'(ID_BASE))
        slot_q[cfg_addr_i[POS_W-1:0]] <= slot_cfg_t'(cfg_wdata_i);
      else if (cfg_addr_i < ADDR_W'(LOW_ADDR))
        id_tab_q[cfg_addr_i[POS_W-1:0]] <= cfg_wdata_i[ID_W-1:0];
      else if (cfg_addr_i == ADDR_W'(LOW_ADDR))
        low_q <= cfg_wdata_i[NUM_SLOTS-1:0];
      else if (cfg_addr_i == ADDR_W'(HIGH_ADDR))
        high_q <= cfg_wdata_i[NUM_SLOTS-1:0];
      else if (cfg_addr_i == ADDR_W'(MODE_ADDR))
        loose_q <= cfg_wdata_i[0];
    end
  end

  // stage 1: slot predicates
  logic [NUM_SLOTS-1:0] hit;
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    bpm_slot_eval u_slot (
      .win_i (in_win_i),
      .cfg_i (slot_q[s]),
      .hit_o (hit[s])
    );
  end

  logic [NUM_SLOTS-1:0] res_q;
  logic                 v1_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      v1_q  <= 1'b0;
    end else begin
      res_q <= hit;
      v1_q  <= in_valid_i;
    end
  end

  // stage 2: group fold, priority, ID
  logic [NUM_SLOTS-1:0] rule_top;
  logic                 any_hit;
  logic [ID_W-1:0]      win_id;

  bpm_group_and #(.N(NUM_SLOTS)) u_group (
    .res_i   (res_q),
    .low_i   (low_q),
    .high_i  (high_q),
    .loose_i (loose_q),
    .out_o   (rule_top)
  );

  bpm_prio_id #(.N(NUM_SLOTS), .ID_W(ID_W)) u_prio (
    .vec_i (rule_top),
    .ids_i (id_tab_q),
    .any_o (any_hit),
    .id_o  (win_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      match_o     <= 1'b0;
      match_id_o  <= '0;
    end else begin
      out_valid_o <= v1_q;
      match_o     <= v1_q && any_hit;
      match_id_o  <= (v1_q && any_hit) ? win_id : '0;
    end
  end

  // cycles since reset, for the latency check only
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (out_valid_o == $past(in_valid_i, 2)))
    else $error("valid latency broken");

  assert_nomatch_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_o |-> (match_id_o == '0))
    else $error("ID not zero without match");

  assert_match_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> out_valid_o)
    else $error("match without valid");
endmodule

// File: tb/sim_byte_pred_matcher.sv
`timescale 1ns/1ps
module sim_byte_pred_matcher;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cfg_we_i = 1'b0;
  logic [6:0]   cfg_addr_i = '0;
  logic [31:0]  cfg_wdata_i = '0;
  logic         in_valid_i = 1'b0;
  logic [127:0] in_win_i = '0;
  logic         out_valid_o, match_o;
  logic [7:0]   match_id_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  byte_pred_matcher u0 (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .in_valid_i, .in_win_i, .out_valid_o, .match_o, .match_id_o
  );

  function automatic logic [136:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5, b15,
                                      input logic m, input logic [7:0] id);
    logic [127:0] w;
    w = '0;
    w[7:0] = b0; w[15:8] = b1; w[23:16] = b2; w[31:24] = b3;
    w[39:32] = b4; w[47:40] = b5; w[127:120] = b15;
    return {id, m, w};
  endfunction

  // tight-mode vectors
  localparam int NT = 14;
  localparam logic [136:0] TV [NT] = '{
    mk("c","a","t",0,0,0,0,        1'b1, 8'h11),
    mk("d","o","g",0,0,0,0,        1'b1, 8'h22),
    mk("a","b","c",0,0,0,0,        1'b1, 8'h33),
    mk("a","b","x",0,0,0,0,        1'b1, 8'h33),
    mk("a","b","y",0,0,0,0,        1'b0, 8'h00),
    mk("c","a","x",0,0,0,0,        1'b0, 8'h00),
    mk("c","a","t",0,"k","7",0,    1'b1, 8'h44),
    mk(0,0,0,0,"K",":",0,          1'b0, 8'h00),
    mk(0,0,0,0,"K","0",0,          1'b1, 8'h44),
    mk(0,0,0,0,"K","/",0,          1'b0, 8'h00),
    mk("d","o","g",0,0,0,8'hFF,    1'b1, 8'h55),
    mk(0,0,0,0,0,0,8'hFF,          1'b1, 8'h55),
    mk(0,0,0,0,0,0,0,              1'b0, 8'h00),
    mk("d","o","c",0,0,0,0,        1'b0, 8'h00)
  };

  // loose-mode vectors
  localparam int NL = 7;
  localparam logic [136:0] LV [NL] = '{
    mk("h","i",0,0,0,0,0,   1'b1, 8'h66),
    mk("a","q","c",0,0,0,0, 1'b1, 8'h77),
    mk("a","q","x",0,0,0,0, 1'b1, 8'h77),
    mk("a","q","z",0,0,0,0, 1'b0, 8'h00),
    mk("h","i","c",0,0,0,0, 1'b1, 8'h66),
    mk("h","j",0,0,0,0,0,   1'b0, 8'h00),
    mk("a","i","x",0,0,0,0, 1'b1, 8'h77)
  };

  function automatic logic [31:0] eqw(input logic [3:0] idx, input logic [7:0] x);
    return {8'd126, 8'(x + 8'h81), 8'hFF, 4'h0, idx};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 7'(a); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic run_stream(input bit loose, input int n);
    logic [136:0] v;
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk_i);
      if (i >= 2) begin
        v = loose ? LV[i-2] : TV[i-2];
        chk(loose ? "R9 loose valid" : "R9 tight valid", 32'(out_valid_o), 32'd1);
        if (loose) begin
          chk($sformatf("R6 R5 match vec %0d", i-2), 32'(match_o), 32'(v[128]));
          chk($sformatf("R6 R8 id vec %0d", i-2), 32'(match_id_o), 32'(v[136:129]));
        end else begin
          chk($sformatf("R2 R3 R4 R5 match vec %0d", i-2), 32'(match_o), 32'(v[128]));
          chk($sformatf("R7 R8 id vec %0d", i-2), 32'(match_id_o), 32'(v[136:129]));
        end
      end
      if (i < n) begin
        v = loose ? LV[i] : TV[i];
        in_valid_i = 1'b1; in_win_i = v[127:0];
      end else begin
        in_valid_i = 1'b0; in_win_i = '0;
      end
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 reset valid", 32'(out_valid_o), 32'd0);
    chk("R10 reset match", 32'(match_o), 32'd0);
    chk("R10 reset id", 32'(match_id_o), 32'd0);
    rst_ni = 1'b1;

    // R10: zero settings never match
    @(negedge clk_i);
    in_valid_i = 1'b1; in_win_i = TV[0][127:0];
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk("R9 one-cycle valid", 32'(out_valid_o), 32'd0);
    @(negedge clk_i);
    chk("R9 two-cycle valid", 32'(out_valid_o), 32'd1);
    chk("R10 cleared settings match", 32'(match_o), 32'd0);
    @(negedge clk_i);
    chk("R9 valid drops", 32'(out_valid_o), 32'd0);

    // R1: tight program
    wr(0, eqw(0, "c")); wr(1, eqw(1, "a")); wr(2, eqw(2, "t"));
    wr(3, eqw(0, "d")); wr(4, eqw(1, "o")); wr(5, eqw(2, "g"));
    wr(6, eqw(2, "c")); wr(7, eqw(2, "x")); wr(8, eqw(0, "a")); wr(9, eqw(1, "b"));
    wr(10, {8'd126, 8'h4B + 8'h81, 8'hDF, 4'h0, 4'd4});   // caseless K
    wr(11, {8'h75, 8'hBA, 8'hFF, 4'h0, 4'd5});            // '0'..'9'
    wr(31, eqw(15, 8'hFF));
    wr(32 + 2, 32'h11); wr(32 + 5, 32'h22); wr(32 + 9, 32'h33);
    wr(32 + 11, 32'h44); wr(32 + 31, 32'h55);
    wr(64, 32'h800004C9);
    wr(65, 32'h80000A24);
    wr(66, 32'd0);
    run_stream(1'b0, NT);

    // R6: loose program, guard slots 2 and 6
    wr(0, eqw(0, "h")); wr(1, eqw(1, "i")); wr(2, {8'h7F, 24'h0});
    wr(3, eqw(2, "c")); wr(4, eqw(2, "x")); wr(5, eqw(0, "a")); wr(6, {8'h7F, 24'h0});
    for (int s = 7; s < 12; s++) wr(s, 32'h0);
    wr(31, 32'h0);
    wr(32 + 2, 32'h66); wr(32 + 6, 32'h77);
    wr(64, 32'h00000019);
    wr(65, 32'h00000044);
    wr(66, 32'd1);
    run_stream(1'b1, NL);

    // R1: rewrite one ID entry
    wr(32 + 2, 32'h99);
    @(negedge clk_i);
    in_valid_i = 1'b1; in_win_i = LV[0][127:0];
    @(negedge clk_i);
    in_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R1 rewritten id", 32'(match_id_o), 32'h99);

    // R10: mid-run reset clears settings
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R10 async reset valid", 32'(out_valid_o), 32'd0);
    rst_ni = 1'b1;
    in_valid_i = 1'b1; in_win_i = LV[0][127:0];
    @(negedge clk_i);
    in_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R10 post-reset valid", 32'(out_valid_o), 32'd1);
    chk("R10 post-reset no match", 32'(match_o), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule